// File: doc/BRIEF.md
# Addressable System Control Bit Latch

This block is a small bank of single-bit control flags that sits on the main processor bus. Any write that lands in its 32-byte window updates exactly one flag. Three address lines pick the flag, and one further address line supplies the value stored in it. The data bus carries nothing the block uses, so software sets or clears a flag by choosing which address to write.

The window repeats across a wide mirror region, and the block answers only writes on the low byte lane. Five of the eight slots hold real state. They drive these controls:

- screen blanking
- the exception vector bank
- a combined flag that selects both the fixed-layer source and the audio ROM bank
- the backup-RAM write unlock
- the palette bank

The other three slots have no storage, and writes to them are discarded. Reads of the window return all-ones and never change a flag.

Top module: `sysctl_bit_latch`

## Requirements
- R1: While `rst` is high at a clock edge, every flag is cleared, so all six control outputs read 0 after that edge.
- R2: A low-lane write into the window stores byte-address bit 4 into the slot given by byte-address bits 3:1. The new value appears at the outputs after the clock edge that samples the write. Slot 0 drives `scr_dark`, slot 1 drives `vec_bank`, slot 6 drives `bram_unlock` and slot 7 drives `pal_bank`.
- R3: The value on `bus_wdata` has no effect on any flag. Writing all-ones data can clear a flag, and writing all-zero data can set one.
- R4: The window matches any byte address whose bits 23:17 equal 7'h1D, which is base 0x3A0000 with every mirror bit in 0x01FFE0 free. Writes whose address has other values in bits 23:17 change no flag.
- R5: A write with `bus_lds` low changes no flag.
- R6: Slot 5 drives both `fix_src` and `audio_bank`. A write to slot 5 updates both outputs to the same value at the same edge.
- R7: Writes to slots 2, 3 and 4 leave every output unchanged.
- R8: While `bus_rd` is high and the address is in the window, `rd_data` is all-ones. At all other times `rd_data` is zero. A read changes no flag.
- R9: A write to one slot leaves every output driven by the other slots unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 23 | Word address, byte-address bits 23:1 |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_lds | input | 1 | Low byte lane enable |
| bus_wdata | input | 16 | Write data, not used for storage |
| rd_data | output | 16 | All-ones during a read that hits the window, else zero |
| scr_dark | output | 1 | Screen blanking flag (slot 0) |
| vec_bank | output | 1 | Vector table bank select (slot 1) |
| fix_src | output | 1 | Fixed-layer source select (slot 5) |
| audio_bank | output | 1 | Audio ROM bank select (slot 5) |
| bram_unlock | output | 1 | Backup-RAM write unlock (slot 6) |
| pal_bank | output | 1 | Palette bank select (slot 7) |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never high together. They also assume that the address, lane and strobe inputs hold steady across each sampling edge, so a write is one sampled cycle whose address fully defines its effect. The bench changes every input only on the falling clock edge and never raises both strobes in the same cycle. Between accesses it returns the strobes to idle, so an observed output change can be traced to exactly one access.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int N_ENTRY = 8;
    localparam int SEL_W   = $clog2(N_ENTRY);

    // Slots that carry a real flip-flop; the rest are write-ignored.
    localparam logic [N_ENTRY-1:0] LIVE_MASK = 8'b1110_0011;

    typedef enum logic [SEL_W-1:0] {
        SLOT_DARK   = 3'd0,
        SLOT_VECT   = 3'd1,
        SLOT_CARDA  = 3'd2,
        SLOT_CARDB  = 3'd3,
        SLOT_CARDR  = 3'd4,
        SLOT_LAYER  = 3'd5,
        SLOT_UNLOCK = 3'd6,
        SLOT_PAL    = 3'd7
    } slot_e;

    typedef struct packed {
        logic  en;
        slot_e sel;
        logic  val;
    } wr_req_t;

    typedef struct packed {
        logic scr_dark;
        logic vec_bank;
        logic fix_src;
        logic audio_bank;
        logic bram_unlock;
        logic pal_bank;
    } ctl_out_t;

    function automatic logic slot_live(slot_e s);
        return LIVE_MASK[s];
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] BASE    = 24'h3A0000,
    parameter logic [ADDR_W-1:0] MIRROR  = 24'h01FFE0,
    parameter int              WIN_BYTES = 32
) (
    input  logic [ADDR_W-1:1] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_lds,
    output wr_req_t           req,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] FREE_BITS  = MIRROR | ADDR_W'(WIN_BYTES - 1);
    localparam logic [ADDR_W-1:0] FIXED_BITS = ~FREE_BITS;

    logic [ADDR_W-1:0] byte_addr;
    logic              in_window;
    slot_e             slot;

    // Low-lane access: byte address is odd.
    assign byte_addr = {bus_addr, 1'b1};
    assign in_window = (byte_addr & FIXED_BITS) == (BASE & FIXED_BITS);
    assign slot      = slot_e'(bus_addr[SEL_W:1]);

    always_comb begin
        req.sel = slot;
        req.val = bus_addr[SEL_W+1];
        req.en  = bus_wr && bus_lds && in_window && slot_live(slot);
    end

    assign rd_hit = bus_rd && in_window;

endmodule

// File: rtl/sysctl_bit_file.sv
module sysctl_bit_file
    import sysctl_pkg::*;
#(
    parameter int                   N    = N_ENTRY,
    parameter logic [N_ENTRY-1:0]   LIVE = LIVE_MASK
) (
    input  logic         clk,
    input  logic         rst,
    input  wr_req_t      req,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        if (LIVE[i]) begin : g_live
            logic bit_r;
            always_ff @(posedge clk) begin
                if (rst)
                    bit_r <= 1'b0;
                else if (req.en && (req.sel == SEL_W'(i)))
                    bit_r <= req.val;
            end
            assign q[i] = bit_r;
        end else begin : g_dead
            assign q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sysctl_out_map.sv
module sysctl_out_map
    import sysctl_pkg::*;
(
    input  logic [N_ENTRY-1:0] q,
    output ctl_out_t           ctl
);
    logic unused_dead_slots;
    assign unused_dead_slots = ^{q[SLOT_CARDA], q[SLOT_CARDB], q[SLOT_CARDR]};

    always_comb begin
        ctl.scr_dark    = q[SLOT_DARK];
        ctl.vec_bank    = q[SLOT_VECT];
        ctl.fix_src     = q[SLOT_LAYER];
        ctl.audio_bank  = q[SLOT_LAYER];
        ctl.bram_unlock = q[SLOT_UNLOCK];
        ctl.pal_bank    = q[SLOT_PAL];
    end

endmodule

// File: rtl/sysctl_bit_latch.sv
module sysctl_bit_latch
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W    = 24,
    parameter int                DATA_W    = 16,
    parameter logic [ADDR_W-1:0] BASE      = 24'h3A0000,
    parameter logic [ADDR_W-1:0] MIRROR    = 24'h01FFE0,
    parameter int                WIN_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:1] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_lds,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              scr_dark,
    output logic              vec_bank,
    output logic              fix_src,
    output logic              audio_bank,
    output logic              bram_unlock,
    output logic              pal_bank
);
    wr_req_t             req;
    logic                rd_hit;
    logic [N_ENTRY-1:0]  slots;
    ctl_out_t            ctl;

    // Stored values come from the address; the data bus is not used.
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata;

    sysctl_addr_decode #(
        .ADDR_W   (ADDR_W),
        .BASE     (BASE),
        .MIRROR   (MIRROR),
        .WIN_BYTES(WIN_BYTES)
    ) u_dec (
        .bus_addr(bus_addr),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_lds (bus_lds),
        .req     (req),
        .rd_hit  (rd_hit)
    );

    sysctl_bit_file #(
        .N   (N_ENTRY),
        .LIVE(LIVE_MASK)
    ) u_bits (
        .clk(clk),
        .rst(rst),
        .req(req),
        .q  (slots)
    );

    sysctl_out_map u_map (
        .q  (slots),
        .ctl(ctl)
    );

    assign rd_data     = rd_hit ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    assign scr_dark    = ctl.scr_dark;
    assign vec_bank    = ctl.vec_bank;
    assign fix_src     = ctl.fix_src;
    assign audio_bank  = ctl.audio_bank;
    assign bram_unlock = ctl.bram_unlock;
    assign pal_bank    = ctl.pal_bank;

endmodule

// File: rtl/sysctl_bit_latch_chk.sv
module sysctl_bit_latch_chk (
    input logic        clk,
    input logic        rst,
    input logic [23:1] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_lds,
    input logic [15:0] rd_data,
    input logic        scr_dark,
    input logic        vec_bank,
    input logic        fix_src,
    input logic        audio_bank,
    input logic        bram_unlock,
    input logic        pal_bank
);
    logic       win;
    logic [2:0] sel;
    logic       val;
    logic       wgo;
    logic [5:0] outs;

    assign win  = (bus_addr[23:17] == 7'h1D);
    assign sel  = bus_addr[3:1];
    assign val  = bus_addr[4];
    assign wgo  = bus_wr && bus_lds && win;
    assign outs = {pal_bank, bram_unlock, audio_bank, fix_src, vec_bank, scr_dark};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (outs == 6'b0));

    // R2
    dark_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wgo && sel == 3'd0) |=> (scr_dark == $past(val)));

    // R2
    pal_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wgo && sel == 3'd7) |=> (pal_bank == $past(val)));

    // R6
    fix_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (wgo && sel == 3'd5) |=> (fix_src == $past(val) && audio_bank == $past(val)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wgo |=> $stable(outs));

    // R7
    dead_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (wgo && (sel == 3'd2 || sel == 3'd3 || sel == 3'd4)) |=> $stable(outs));

    // R9
    other_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wgo && sel == 3'd7) |=> $stable(outs[4:0]));

    // R8
    rd_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && win) |-> (rd_data == 16'hFFFF));

endmodule

bind sysctl_bit_latch sysctl_bit_latch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_lds    (bus_lds),
    .rd_data    (rd_data),
    .scr_dark   (scr_dark),
    .vec_bank   (vec_bank),
    .fix_src    (fix_src),
    .audio_bank (audio_bank),
    .bram_unlock(bram_unlock),
    .pal_bank   (pal_bank)
);

// File: tb/tb_sysctl_bit_latch.sv
`timescale 1ns/1ps
module tb_sysctl_bit_latch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:1] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_lds = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] rd_data;
    logic        scr_dark, vec_bank, fix_src, audio_bank, bram_unlock, pal_bank;

    always #2.5 clk = ~clk;

    sysctl_bit_latch dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_lds(bus_lds), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .scr_dark(scr_dark), .vec_bank(vec_bank),
        .fix_src(fix_src), .audio_bank(audio_bank),
        .bram_unlock(bram_unlock), .pal_bank(pal_bank)
    );

    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;
    logic [7:0] model  = 8'h00;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    // Output order {pal, unlock, audio, fix, vect, dark}
    function automatic logic [5:0] exp_outs(logic [7:0] m);
        return {m[7], m[6], m[5], m[5], m[1], m[0]};
    endfunction

    function automatic logic [23:0] mk_addr(logic [23:0] base, logic [23:0] mir,
                                            logic [2:0] s, logic v);
        return base | mir | {19'd0, v, s, 1'b1};
    endfunction

    function automatic logic [5:0] cur_outs();
        return {pal_bank, bram_unlock, audio_bank, fix_src, vec_bank, scr_dark};
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [5:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (cur_outs() !== e) begin
                errors++;
                $display("FAIL %s outs got %b exp %b", t, cur_outs(), e);
            end
        end
    end

    task automatic bus_write(input logic [23:0] a, input logic lds,
                             input logic [15:0] d, input string tag);
        @(negedge clk);
        bus_addr = a[23:1]; bus_wr = 1'b1; bus_rd = 1'b0;
        bus_lds = lds; bus_wdata = d;
        if (a[23:17] == 7'h1D && lds && !(a[3:1] inside {3'd2, 3'd3, 3'd4}))
            model[a[3:1]] = a[4];
        @(posedge clk); #1;
        exp_q.push_back(exp_outs(model));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_lds = 1'b0;
    endtask

    task automatic bus_read(input logic [23:0] a, input logic [15:0] exp_rd,
                            input string tag);
        @(negedge clk);
        bus_addr = a[23:1]; bus_rd = 1'b1; bus_wr = 1'b0; bus_lds = 1'b1;
        #1;
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data got %h exp %h", tag, rd_data, exp_rd);
        end
        @(posedge clk); #1;
        exp_q.push_back(exp_outs(model));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0; bus_lds = 1'b0;
    endtask

    task automatic pulse_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        model = 8'h00;
        exp_q.push_back(exp_outs(model));
        tag_q.push_back(tag);
        @(negedge clk);
        rst = 1'b0;
    endtask

    logic [23:0] mirrors [4] = '{24'h000000, 24'h01FFE0, 24'h00A5A0, 24'h015420};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (cur_outs() !== 6'b0) begin
            errors++;
            $display("FAIL R1 reset outs got %b exp %b", cur_outs(), 6'b0);
        end
        rst = 1'b0;

        // R2 / R3 / R6 / R7 / R9: set each slot via mirrors with zero data
        for (int s = 0; s < 8; s++) begin
            string t;
            if (s inside {2, 3, 4})  t = "R7 dead slot set";
            else if (s == 5)         t = "R6 layer+audio set";
            else                     t = "R2 R9 slot set";
            bus_write(mk_addr(24'h3A0000, mirrors[s % 4], 3'(s), 1'b1), 1'b1, 16'h0000, t);
        end

        // R4: outside the window
        bus_write(mk_addr(24'h380000, 24'h0, 3'd7, 1'b0), 1'b1, 16'h0000, "R4 out of window low");
        bus_write(mk_addr(24'h3C0000, 24'h0, 3'd0, 1'b0), 1'b1, 16'h0000, "R4 out of window high");

        // R5: low lane not enabled
        bus_write(mk_addr(24'h3A0000, 24'h0, 3'd0, 1'b0), 1'b0, 16'h0000, "R5 lane off");

        // R3: data ones clears, data zero sets
        bus_write(mk_addr(24'h3A0000, 24'h01FFE0, 3'd6, 1'b0), 1'b1, 16'hFFFF, "R3 clear with ones data");
        bus_write(mk_addr(24'h3A0000, 24'h000020, 3'd6, 1'b1), 1'b1, 16'h0000, "R3 set with zero data");

        // R8: reads
        bus_read(mk_addr(24'h3A0000, 24'h00FFE0, 3'd7, 1'b0), 16'hFFFF, "R8 read in window");
        bus_read(mk_addr(24'h340000, 24'h0, 3'd7, 1'b0), 16'h0000, "R8 read outside window");

        // R2 / R3 / R6: clear each slot with ones data
        for (int s = 0; s < 8; s++) begin
            string t;
            if (s inside {2, 3, 4})  t = "R7 dead slot clear";
            else if (s == 5)         t = "R6 layer+audio clear";
            else                     t = "R2 R9 slot clear";
            bus_write(mk_addr(24'h3A0000, mirrors[(s + 1) % 4], 3'(s), 1'b0), 1'b1, 16'hFFFF, t);
        end

        // R1: reset clears set flags
        bus_write(mk_addr(24'h3A0000, 24'h0, 3'd1, 1'b1), 1'b1, 16'h1234, "R2 vect set");
        bus_write(mk_addr(24'h3A0000, 24'h0, 3'd5, 1'b1), 1'b1, 16'h5678, "R6 layer set");
        pulse_reset("R1 reset mid-run");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule